// File: doc/BRIEF.md
# Reference-Disciplined One-Second Tick

This block makes a one-second tick from an oscillator-rate enable and can keep that tick in step with a slower external reference. The tick comes from a sub-second counter that advances on every oscillator enable. When the shared pin is configured as an input, rising reference edges are counted down to one derived edge per second. The number of oscillator ticks between derived edges is measured. If that count is close enough to a nominal second, the block locks to the phase offset it finds at that moment. From then on it watches how far the sub-second counter drifts from that offset. Once the drift reaches a fixed step, it moves the sub-second counter by that step, once.

A sticky loss-of-signal flag reports three cases: the input is disabled, the reference has gone quiet, or its frequency is out of range. When the pin is configured as an output, the block drives a selectable square wave or a static level onto it. The default oscillator enable rate is twice 32.768 kHz, so one second is 2^16 ticks and the default step of 512 ticks is about 7.8 ms.

Top module: `refclk_discipline`

## Requirements
- R1: While refEn is 1, rateSel 00/01/10/11 sets how many reference rising edges make one derived second: DIV0/DIV1/DIV2/DIV3 (defaults 1, 50, 60, 32768). A reference at the matching rate locks without raising losFlag.
- R2: locked rises once a derived-second period in tolerance follows the first derived edge after enabling or after a gap. locked is low in the cycle after refEn is 0 and after reset.
- R3: A lock holds the phase offset found when it was taken. With a reference matching the tick rate, tick1Hz spacing stays exactly 2^SEC_BITS ticks. This also holds after a relock at a new phase.
- R4: When the locked skew reaches +STEP ticks (tick early), exactly one second is lengthened by STEP. At -STEP ticks (tick late), exactly one second is shortened by STEP. The move is applied only in the second quarter of the sub-second count.
- R5: A measured period outside 2^SEC_BITS ± TOL ticks drops the lock and sets losFlag. The tick then runs uncorrected at 2^SEC_BITS.
- R6: losFlag resets to 1. It sets when refEn is 0, on a gap, or on an out-of-tolerance period. A one-cycle losClear clears it, but a set condition in the same cycle wins.
- R7: If no reference rising edge arrives within 2 × (2^SEC_BITS / divisor) ticks, losFlag is set and the lock is dropped.
- R8: A losClear while the most recent period was out of tolerance stops later frequency errors from setting losFlag. The next good period or refEn = 0 ends this suppression.
- R9: With refEn = 0 and sqwEn = 1, sqwOut is chosen by rateSel. 00 is the top bit of the corrected sub-second counter. 01, 10 and 11 are free-running tick counts divided by 16, 8 and 2.
- R10: With refEn = 0 and sqwEn = 0, sqwOut equals outLevel one cycle later. With refEn = 1, sqwOut is 1 (pin released).
- R11: tick1Hz is a one-cycle pulse, registered from a cycle with oscTick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | Oscillator-rate enable |
| refIn | input | 1 | Synchronized reference level |
| refEn | input | 1 | 1 = pin is a reference input |
| rateSel | input | 2 | Reference rate or square-wave rate |
| sqwEn | input | 1 | Square-wave enable in output mode |
| outLevel | input | 1 | Static pin level in output mode |
| losClear | input | 1 | One-cycle strobe that clears losFlag |
| tick1Hz | output | 1 | Corrected one-second pulse |
| sqwOut | output | 1 | Registered pin output value |
| losFlag | output | 1 | Sticky loss-of-signal flag |
| locked | output | 1 | Tick is disciplined to the reference |

## Verification
The assertions assume the following about the inputs:
- refIn is already synchronized to clk.
- losClear lasts a single cycle.
- rateSel changes only while refEn is low.

The stimulus keeps to these rules. It holds oscTick high on every cycle, drops refEn before every rate change, and drives all inputs away from the sampling edge. Reference periods are chosen on both sides of the tolerance band and on both sides of the nominal second. Start phases and output levels are drawn at random from a fixed seed.

// File: rtl/refclk_discipline_pkg.sv
package refclk_discipline_pkg;
  typedef struct packed {
    logic restart;
    logic capture;
    logic advance;
    logic retard;
  } discStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACQ,
    ST_LOCK
  } discState_t;
endpackage

// File: rtl/refclk_dp.sv
module refclk_dp
  import refclk_discipline_pkg::*;
#(
  parameter int SEC_BITS = 16,
  parameter int STEP     = 512,
  parameter int TOL      = 524,
  parameter int DIV0     = 1,
  parameter int DIV1     = 50,
  parameter int DIV2     = 60,
  parameter int DIV3     = 32768
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscTick,
  input  logic        refIn,
  input  logic        refEn,
  input  logic [1:0]  rateSel,
  input  logic        sqwEn,
  input  logic        outLevel,
  input  discStrobe_t str,
  output logic        extSec,
  output logic        periodOk,
  output logic        gapExpired,
  output logic        skewLate,
  output logic        skewEarly,
  output logic        adjPending,
  output logic        tick1Hz,
  output logic        sqwOut
);
  localparam int ONE_SEC = 1 << SEC_BITS;
  localparam int PW      = SEC_BITS + 2;
  localparam int GW      = SEC_BITS + 2;
  localparam int MAX01   = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX23   = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAXDIV  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int DW      = $clog2(MAXDIV + 1);
  localparam int RATE_DIV [4] = '{DIV0, DIV1, DIV2, DIV3};
  localparam logic [PW-1:0] PER_LO = PW'(ONE_SEC - TOL);
  localparam logic [PW-1:0] PER_HI = PW'(ONE_SEC + TOL);

  logic [DW-1:0] divLast [4];
  logic [GW-1:0] gapLim  [4];

  for (genvar i = 0; i < 4; i++) begin : gRate
    localparam int GAP_RAW = (2 * ONE_SEC) / RATE_DIV[i];
    localparam int GAP     = (GAP_RAW < 2) ? 2 : GAP_RAW;
    assign divLast[i] = DW'(RATE_DIV[i] - 1);
    assign gapLim[i]  = GW'(GAP);
  end

  logic [SEC_BITS-1:0] subCnt;
  logic [SEC_BITS-1:0] lockPhase;
  logic [3:0]          rawCnt;
  logic                pendAdv;
  logic                pendRet;
  logic                refPrev;
  logic [DW-1:0]       refDivCnt;
  logic [PW-1:0]       perCnt;
  logic [PW-1:0]       measured;
  logic [GW-1:0]       gapCnt;
  logic                refRise;
  logic                inWindow;
  logic                tap;
  logic signed [SEC_BITS-1:0] skew;

  assign refRise    = refIn & ~refPrev;
  assign extSec     = refRise && (refDivCnt >= divLast[rateSel]);
  assign measured   = perCnt + PW'(oscTick);
  assign periodOk   = (measured >= PER_LO) && (measured <= PER_HI);
  assign gapExpired = (gapCnt >= gapLim[rateSel]);
  assign skew       = $signed(subCnt - lockPhase);
  assign skewLate   = (skew >= STEP);
  assign skewEarly  = (skew <= -STEP);
  assign inWindow   = (subCnt[SEC_BITS-1 -: 2] == 2'b01);
  assign adjPending = pendAdv | pendRet;

  // Sub-second counter with window-gated one-time step corrections
  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt  <= '0;
      rawCnt  <= '0;
      pendAdv <= 1'b0;
      pendRet <= 1'b0;
      tick1Hz <= 1'b0;
    end else begin
      tick1Hz <= oscTick && (subCnt == '1);
      if (oscTick) begin
        rawCnt <= rawCnt + 4'd1;
        if (inWindow && pendAdv) begin
          subCnt <= subCnt + SEC_BITS'(STEP + 1);
        end else if (inWindow && pendRet) begin
          subCnt <= subCnt + SEC_BITS'(1) - SEC_BITS'(STEP);
        end else begin
          subCnt <= subCnt + SEC_BITS'(1);
        end
      end
      if (str.restart) begin
        pendAdv <= 1'b0;
        pendRet <= 1'b0;
      end else if (str.advance) begin
        pendAdv <= 1'b1;
      end else if (str.retard) begin
        pendRet <= 1'b1;
      end else if (oscTick && inWindow) begin
        pendAdv <= 1'b0;
        pendRet <= 1'b0;
      end
    end
  end

  // Reference divide-down, period and gap measurement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refPrev   <= 1'b0;
      refDivCnt <= '0;
      perCnt    <= '0;
      gapCnt    <= '0;
      lockPhase <= '0;
    end else begin
      refPrev <= refIn;
      if (str.capture) lockPhase <= subCnt;
      if (str.restart) begin
        refDivCnt <= '0;
        perCnt    <= '0;
        gapCnt    <= '0;
      end else begin
        if (refRise) refDivCnt <= extSec ? '0 : refDivCnt + DW'(1);
        if (extSec) perCnt <= '0;
        else if (oscTick && (perCnt != '1)) perCnt <= perCnt + PW'(1);
        if (refRise) gapCnt <= '0;
        else if (oscTick && !gapExpired) gapCnt <= gapCnt + GW'(1);
      end
    end
  end

  // Pin output selection
  always_comb begin
    case (rateSel)
      2'b00:   tap = subCnt[SEC_BITS-1];
      2'b01:   tap = rawCnt[3];
      2'b10:   tap = rawCnt[2];
      default: tap = rawCnt[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) sqwOut <= 1'b1;
    else if (refEn) sqwOut <= 1'b1;
    else if (sqwEn) sqwOut <= tap;
    else sqwOut <= outLevel;
  end
endmodule

// File: rtl/refclk_ctrl.sv
module refclk_ctrl
  import refclk_discipline_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refEn,
  input  logic        losClear,
  input  logic        extSec,
  input  logic        periodOk,
  input  logic        gapExpired,
  input  logic        skewLate,
  input  logic        skewEarly,
  input  logic        adjPending,
  output discStrobe_t str,
  output logic        losFlag,
  output logic        locked
);
  discState_t state, nextState;
  logic freqErr;
  logic goodPer;
  logic freqBad;
  logic inhibit;
  logic losSet;

  always_comb begin
    str         = '0;
    str.restart = !refEn;
    nextState   = state;
    freqErr     = 1'b0;
    goodPer     = 1'b0;
    if (!refEn) begin
      nextState = ST_IDLE;
    end else if (gapExpired) begin
      nextState = ST_WAIT;
    end else begin
      case (state)
        ST_IDLE: nextState = ST_WAIT;
        ST_WAIT: if (extSec) nextState = ST_ACQ;
        ST_ACQ: begin
          if (extSec) begin
            if (periodOk) begin
              goodPer     = 1'b1;
              str.capture = 1'b1;
              nextState   = ST_LOCK;
            end else begin
              freqErr = 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (extSec) begin
            if (!periodOk) begin
              freqErr   = 1'b1;
              nextState = ST_ACQ;
            end else begin
              goodPer = 1'b1;
              if (!adjPending) begin
                str.retard  = skewLate;
                str.advance = skewEarly;
              end
            end
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign losSet = !refEn || gapExpired || (freqErr && !inhibit);
  assign locked = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      losFlag <= 1'b1;
      freqBad <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      state <= nextState;
      if (losSet) losFlag <= 1'b1;
      else if (losClear) losFlag <= 1'b0;
      if (!refEn) freqBad <= 1'b0;
      else if (freqErr) freqBad <= 1'b1;
      else if (goodPer) freqBad <= 1'b0;
      if (!refEn || goodPer) inhibit <= 1'b0;
      else if (losClear && (freqBad || freqErr)) inhibit <= 1'b1;
    end
  end
endmodule

// File: rtl/refclk_discipline.sv
module refclk_discipline
  import refclk_discipline_pkg::*;
#(
  parameter int SEC_BITS = 16,
  parameter int STEP     = 512,
  parameter int TOL      = 524,
  parameter int DIV0     = 1,
  parameter int DIV1     = 50,
  parameter int DIV2     = 60,
  parameter int DIV3     = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       refIn,
  input  logic       refEn,
  input  logic [1:0] rateSel,
  input  logic       sqwEn,
  input  logic       outLevel,
  input  logic       losClear,
  output logic       tick1Hz,
  output logic       sqwOut,
  output logic       losFlag,
  output logic       locked
);
  discStrobe_t str;
  logic extSec, periodOk, gapExpired, skewLate, skewEarly, adjPending;

  refclk_dp #(
    .SEC_BITS(SEC_BITS), .STEP(STEP), .TOL(TOL),
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) dp (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .refIn(refIn),
    .refEn(refEn), .rateSel(rateSel), .sqwEn(sqwEn), .outLevel(outLevel),
    .str(str), .extSec(extSec), .periodOk(periodOk), .gapExpired(gapExpired),
    .skewLate(skewLate), .skewEarly(skewEarly), .adjPending(adjPending),
    .tick1Hz(tick1Hz), .sqwOut(sqwOut)
  );

  refclk_ctrl ctrl (
    .clk(clk), .rstN(rstN), .refEn(refEn), .losClear(losClear),
    .extSec(extSec), .periodOk(periodOk), .gapExpired(gapExpired),
    .skewLate(skewLate), .skewEarly(skewEarly), .adjPending(adjPending),
    .str(str), .losFlag(losFlag), .locked(locked)
  );
endmodule

// File: rtl/refclk_discipline_chk.sv
module refclk_discipline_chk (
  input logic clk,
  input logic rstN,
  input logic oscTick,
  input logic refEn,
  input logic sqwEn,
  input logic outLevel,
  input logic losClear,
  input logic tick1Hz,
  input logic sqwOut,
  input logic losFlag,
  input logic locked
);
  assert_los_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !refEn |=> losFlag);

  assert_los_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (losFlag && !losClear) |=> losFlag);

  assert_unlock_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !refEn |=> !locked);

  assert_tick_from_osc_R11: assert property (@(posedge clk) disable iff (!rstN)
    tick1Hz |-> $past(oscTick));

  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    tick1Hz |=> !tick1Hz);

  assert_pin_released_R10: assert property (@(posedge clk) disable iff (!rstN)
    refEn |=> sqwOut);

  assert_static_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!refEn && !sqwEn) |=> (sqwOut == $past(outLevel)));
endmodule

bind refclk_discipline refclk_discipline_chk chk (
  .clk(clk), .rstN(rstN), .oscTick(oscTick), .refEn(refEn), .sqwEn(sqwEn),
  .outLevel(outLevel), .losClear(losClear), .tick1Hz(tick1Hz),
  .sqwOut(sqwOut), .losFlag(losFlag), .locked(locked)
);

// File: tb/refclk_discipline_test.sv
module refclk_discipline_test;
  localparam int SB  = 9;
  localparam int SEC = 1 << SB;
  localparam int ST  = 16;
  localparam int TL  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, oscTick = 1'b1, refIn = 1'b0, refEn = 1'b0;
  logic [1:0] rateSel = 2'b00;
  logic sqwEn = 1'b0, outLevel = 1'b0, losClear = 1'b0;
  logic tick1Hz, sqwOut, losFlag, locked;

  refclk_discipline #(.SEC_BITS(SB), .STEP(ST), .TOL(TL),
    .DIV0(1), .DIV1(4), .DIV2(8), .DIV3(64)) uut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .refIn(refIn), .refEn(refEn),
    .rateSel(rateSel), .sqwEn(sqwEn), .outLevel(outLevel), .losClear(losClear),
    .tick1Hz(tick1Hz), .sqwOut(sqwOut), .losFlag(losFlag), .locked(locked));

  int total = 0, bad = 0, cyc = 0;
  int lastTick = -1, nBase = 0, nLong = 0, nShort = 0, nOther = 0;
  bit monOn = 0, refRun = 0;
  int refHalf = 256, halfCnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (tick1Hz) begin
      if (monOn && lastTick >= 0) begin
        if (cyc - lastTick == SEC) nBase++;
        else if (cyc - lastTick == SEC + ST) nLong++;
        else if (cyc - lastTick == SEC - ST) nShort++;
        else nOther++;
      end
      lastTick = cyc;
    end
  end

  always @(negedge clk) begin
    if (!refRun) begin
      refIn = 1'b0;
      halfCnt = 0;
    end else begin
      halfCnt++;
      if (halfCnt >= refHalf) begin
        refIn = ~refIn;
        halfCnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearLos();
    @(negedge clk) losClear = 1'b1;
    @(negedge clk) losClear = 1'b0;
  endtask

  task automatic resetStats();
    nBase = 0; nLong = 0; nShort = 0; nOther = 0;
  endtask

  task automatic sqwPeriod(output int per);
    int t0 = -1;
    logic prev = sqwOut;
    per = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (sqwOut && !prev) begin
        if (t0 < 0) t0 = cyc;
        else begin
          per = cyc - t0;
          break;
        end
      end
      prev = sqwOut;
    end
  endtask

  task automatic restartRef(input logic [1:0] rate, input int half);
    refEn = 1'b0; refRun = 0;
    waitClk(4);
    rateSel = rate;
    waitClk(2);
    refEn = 1'b1;
    refHalf = half; refRun = 1;
  endtask

  function automatic int expSqw(input int r);
    case (r)
      0: return SEC;
      1: return 16;
      2: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic int halfFor(input int r);
    case (r)
      1: return SEC / 8;
      2: return SEC / 16;
      3: return SEC / 128;
      default: return SEC / 2;
    endcase
  endfunction

  initial begin : watchdog
    #(4 * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int per;
    int seedv;
    logic lvl;
    seedv = $urandom(32'h1d5e);
    waitClk(5);
    rstN = 1'b1;
    @(negedge clk);
    check(losFlag == 1'b1, "R6 reset los", losFlag, 1);
    check(locked == 1'b0, "R2 reset locked", locked, 0);
    check(tick1Hz == 1'b0, "R11 reset tick", tick1Hz, 0);

    // static level, random values
    for (int i = 0; i < 4; i++) begin
      lvl = 1'($urandom_range(0, 1));
      outLevel = lvl;
      waitClk(2);
      check(sqwOut == lvl, "R10 static level", sqwOut, lvl);
    end

    // square-wave rates
    sqwEn = 1'b1;
    for (int r = 0; r < 4; r++) begin
      rateSel = 2'(r);
      waitClk(2);
      sqwPeriod(per);
      check(per == expSqw(r), "R9 square period", per, expSqw(r));
    end
    sqwEn = 1'b0;

    clearLos();
    waitClk(2);
    check(losFlag == 1'b1, "R6 set beats clear", losFlag, 1);

    // lock on an exact reference, random start phase
    rateSel = 2'b00;
    waitClk($urandom_range(0, 300));
    restartRef(2'b00, SEC / 2);
    waitClk(3);
    check(sqwOut == 1'b1, "R10 pin released", sqwOut, 1);
    waitClk(1300);
    check(locked == 1'b1, "R2 locks", locked, 1);
    clearLos();
    waitClk(3);
    check(losFlag == 1'b0, "R6 clear", losFlag, 0);
    resetStats(); monOn = 1;
    waitClk(5 * SEC + 50);
    monOn = 0;
    check(nBase >= 4 && nLong == 0 && nShort == 0 && nOther == 0,
          "R3 offset held", nLong + nShort + nOther, 0);

    // reference slower than tick: one-time lengthening
    refHalf = SEC / 2 + 2;
    waitClk(SEC);
    resetStats(); monOn = 1;
    waitClk(20 * SEC);
    monOn = 0;
    check(nLong >= 3, "R4 lengthen count", nLong, 3);
    check(nShort == 0 && nOther == 0, "R4 lengthen only", nShort + nOther, 0);
    check(locked == 1'b1 && losFlag == 1'b0, "R4 lock kept", {locked, losFlag}, 2);

    // reference faster than tick: one-time shortening
    refHalf = SEC / 2 - 2;
    waitClk(SEC);
    resetStats(); monOn = 1;
    waitClk(20 * SEC);
    monOn = 0;
    check(nShort >= 3, "R4 shorten count", nShort, 3);
    check(nLong == 0 && nOther == 0, "R4 shorten only", nLong + nOther, 0);

    // other rate selections
    for (int r = 1; r < 4; r++) begin
      restartRef(2'(r), halfFor(r));
      waitClk(4 * SEC + 200);
      clearLos();
      waitClk(SEC + 200);
      check(locked == 1'b1 && losFlag == 1'b0, "R1 rate lock", {locked, losFlag}, 2);
      resetStats(); monOn = 1;
      waitClk(3 * SEC + 50);
      monOn = 0;
      check(nBase >= 2 && nLong + nShort + nOther == 0, "R1 rate spacing",
            nLong + nShort + nOther, 0);
    end

    // out-of-tolerance reference (period 540)
    restartRef(2'b00, 270);
    waitClk(400);
    clearLos();
    waitClk(3);
    check(losFlag == 1'b0, "R6 cleared before error", losFlag, 0);
    waitClk(500);
    check(losFlag == 1'b1, "R5 freq error sets los", losFlag, 1);
    check(locked == 1'b0, "R5 no lock", locked, 0);
    resetStats(); monOn = 1;
    waitClk(3 * SEC + 50);
    monOn = 0;
    check(nBase >= 2 && nLong + nShort + nOther == 0, "R5 uncorrected",
          nLong + nShort + nOther, 0);

    // clear while out of tolerance suppresses further detection
    clearLos();
    waitClk(2200);
    check(losFlag == 1'b0, "R8 suppressed", losFlag, 0);
    check(locked == 1'b0, "R8 still unlocked", locked, 0);

    // good reference again, then it stops
    refHalf = SEC / 2;
    waitClk(2000);
    clearLos();
    waitClk(3);
    check(locked == 1'b1 && losFlag == 1'b0, "R7 prelock", {locked, losFlag}, 2);
    refRun = 0;
    waitClk(1100);
    check(losFlag == 1'b1, "R7 gap sets los", losFlag, 1);
    check(locked == 1'b0, "R7 gap unlocks", locked, 0);

    // reacquire at a new random phase
    waitClk($urandom_range(0, 400));
    refHalf = SEC / 2; refRun = 1;
    waitClk(1300);
    check(locked == 1'b1, "R3 relock", locked, 1);
    clearLos();
    resetStats(); monOn = 1;
    waitClk(5 * SEC + 50);
    monOn = 0;
    check(nBase >= 4 && nLong + nShort + nOther == 0, "R3 new offset held",
          nLong + nShort + nOther, 0);

    refEn = 1'b0; refRun = 0;
    waitClk(2);
    check(losFlag == 1'b1 && locked == 1'b0, "R6 disable sets los", {losFlag, locked}, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule